// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit timer that advances once per instruction cycle, which is one clock in four, after a selectable prescaler of 1, 4 or 16 instruction cycles. At every step the running count is compared with an 8-bit period value. When the two are equal, the step loads zero instead of incrementing and a one-clock match pulse is produced. That pulse can serve as a shift clock for a serial unit outside the block. The match events feed a postscaler with a programmable ratio from 1 to 16. When the postscaler completes its run, it raises a sticky interrupt flag and starts over.

Software reaches the block through a small register bus with four addresses: the count, the period, a control word and the flag. A write to the count or to the control word restarts both the prescaler and the postscaler. A control write leaves the count as it is. While the enable bit is clear, the count and both scalers hold.

Top module: `pmt_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control word reads 00h (disabled), the flag reads 0, and `match_pulse` and `irq` are low.
- R2: Address 0 is the count, address 1 the period, address 2 the control word and address 3 the flag. `bus_rdata` follows `bus_addr` combinationally. The control word holds the prescaler select in bits [1:0], the postscaler ratio minus one in bits [5:2] and the enable in bit 6. Bit 7 of the control word reads 0, and the flag is read in bit 0.
- R3: An instruction tick occurs on every fourth rising clock edge, the first one on the fourth edge after reset is released. With the timer enabled, the count steps once every N ticks, where prescaler select 00 gives N=1, 01 gives N=4, and 10 or 11 give N=16.
- R4: A step taken while the count equals the period loads 00h. `match_pulse` is high for the one clock that follows that edge. Any other step adds one to the count.
- R5: With postscaler field value m, the flag is set on the edge of the (m+1)-th match after the postscaler was cleared, and the postscaler then restarts from zero.
- R6: A write to the count or to the control word clears the prescaler and the postscaler, and no step is taken on that edge.
- R7: A write to the control word leaves the count unchanged.
- R8: While the enable bit is 0, the count, the prescaler and the postscaler hold their values.
- R9: Any write to address 3 clears the flag. A flag set on the same edge takes priority. `irq` mirrors the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| match_pulse | output | 1 | One-clock pulse after each period match |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Every result is due on a known edge. A write takes effect on the edge after the strobe is set up. The k-th instruction tick after a control write falls on the k-th edge whose index since reset release is 3 modulo 4. The first match is due on tick (P+1)·N and the flag on tick M·(P+1)·N. `match_pulse` and the flag both become visible in the clock that follows that edge. The bench counts edges itself, computes these indices, and samples outputs and register reads on falling edges, so that each observation can be tied to the exact rising edge that produced it.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int DATA_W  = 8;
  localparam int PRE_W   = 4;
  localparam int POST_W  = 4;
  localparam int PHASES  = 4;

  localparam logic [1:0] ADDR_COUNT  = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  typedef struct packed {
    logic              en;
    logic [POST_W-1:0] post_m1;
    logic [1:0]        presc_sel;
  } ctrl_t;

  // terminal value of the prescaler counter for each select code
  function automatic logic [PRE_W-1:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(0);
      2'b01:   return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction

  // count value after a step
  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] period);
    return (cur == period) ? '0 : cur + 1'b1;
  endfunction
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PHASES = 4,
  parameter int PRE_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             cyc_tick,
  output logic             pre_tick,
  output logic [PRE_W-1:0] presc_cnt
);
  generate
    if (PHASES > 1) begin : g_div
      localparam int PH_W = $clog2(PHASES);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + 1'b1;
      end
      assign cyc_tick = (phase == PH_LAST);
    end else begin : g_nodiv
      assign cyc_tick = 1'b1;
    end
  endgenerate

  assign pre_tick = cyc_tick && run && !clr && (presc_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               presc_cnt <= '0;
    else if (clr)             presc_cnt <= '0;
    else if (cyc_tick && run) presc_cnt <= (presc_cnt == limit) ? '0 : presc_cnt + 1'b1;
  end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter
  import pmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              hit
);
  assign hit = step && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= next_count(count, period);
  end
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  input  logic [POST_W-1:0] last,
  output logic [POST_W-1:0] post_cnt,
  output logic              term
);
  assign term = evt && (post_cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    post_cnt <= '0;
    else if (clr)  post_cnt <= '0;
    else if (term) post_cnt <= '0;
    else if (evt)  post_cnt <= post_cnt + 1'b1;
  end
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              match_pulse,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] count;
  logic              flag_q;
  logic              match_q;

  logic cnt_wr, per_wr, ctrl_wr, flag_wr, scaler_clr;
  logic cyc_tick, pre_tick, match_evt, post_term;
  logic [PRE_W-1:0]  presc_cnt;
  logic [POST_W-1:0] post_cnt;

  assign cnt_wr     = bus_we && (bus_addr == ADDR_COUNT);
  assign per_wr     = bus_we && (bus_addr == ADDR_PERIOD);
  assign ctrl_wr    = bus_we && (bus_addr == ADDR_CTRL);
  assign flag_wr    = bus_we && (bus_addr == ADDR_FLAG);
  assign scaler_clr = cnt_wr || ctrl_wr;

  pmt_prescaler #(.PHASES(PHASES), .PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.en),
    .clr       (scaler_clr),
    .limit     (presc_limit(ctrl_q.presc_sel)),
    .cyc_tick  (cyc_tick),
    .pre_tick  (pre_tick),
    .presc_cnt (presc_cnt)
  );

  pmt_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (pre_tick),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .period   (period_q),
    .count    (count),
    .hit      (match_evt)
  );

  pmt_postscaler #(.POST_W(POST_W)) u_post (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (scaler_clr),
    .evt      (match_evt),
    .last     (ctrl_q.post_m1),
    .post_cnt (post_cnt),
    .term     (post_term)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (ctrl_wr) ctrl_q   <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
      if (per_wr)  period_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_evt;
      if (post_term)    flag_q <= 1'b1;
      else if (flag_wr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_COUNT:  bus_rdata = count;
      ADDR_PERIOD: bus_rdata = period_q;
      ADDR_CTRL:   bus_rdata = DATA_W'(ctrl_q);
      default:     bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
    endcase
  end

  assign match_pulse = match_q;
  assign irq         = flag_q;
endmodule

// File: rtl/pmt_timer_checker.sv
module pmt_timer_checker
  import pmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic              flag_wr,
  input logic              cyc_tick,
  input logic              pre_tick,
  input logic              post_term,
  input logic [PRE_W-1:0]  presc_cnt,
  input logic [POST_W-1:0] post_cnt,
  input logic [DATA_W-1:0] count,
  input logic              match_pulse,
  input logic              irq
);
  AST_STEP_ON_INSN: assert property (@(posedge clk) disable iff (!rst_n) pre_tick |-> cyc_tick); // R3
  AST_MATCH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n) match_pulse |-> (count == '0)); // R4
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> match_pulse); // R5
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cnt_wr || ctrl_wr) |=> (presc_cnt == '0 && post_cnt == '0)); // R6
  AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && !cnt_wr) |=> $stable(count)); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!en && !cnt_wr && !ctrl_wr) |=> ($stable(count) && $stable(presc_cnt) && $stable(post_cnt))); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (flag_wr && !post_term) |=> !irq); // R9
endmodule

bind pmt_timer pmt_timer_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (ctrl_q.en),
  .cnt_wr      (cnt_wr),
  .ctrl_wr     (ctrl_wr),
  .flag_wr     (flag_wr),
  .cyc_tick    (cyc_tick),
  .pre_tick    (pre_tick),
  .post_term   (post_term),
  .presc_cnt   (presc_cnt),
  .post_cnt    (post_cnt),
  .count       (count),
  .match_pulse (match_pulse),
  .irq         (irq)
);

// File: tb/pmt_timer_test.sv
`timescale 1ns/1ps
module pmt_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       match_pulse;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int edge_n = 0;
  int wr_edge = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  pmt_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .match_pulse (match_pulse),
    .irq         (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // write on the next rising edge; wr_edge records that edge's index
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    wr_edge = edge_n;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  function automatic int ratio(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  // edge index of the k-th instruction tick after edge w
  function automatic int tick_edge(input int w, input int k);
    int first;
    first = w + 1;
    while (first % 4 != 3) first++;
    return first + 4 * (k - 1);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int plist[4] = '{0, 1, 2, 5};
    int mlist[3] = '{0, 2, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2 reset values through the register map
    rd(2'd0, rv); check("R1 count", rv, 0);
    rd(2'd1, rv); check("R1 period", rv, 255);
    rd(2'd2, rv); check("R1 ctrl", rv, 0);
    rd(2'd3, rv); check("R1 flag", rv, 0);
    check("R1 irq", irq, 0);
    check("R1 match", match_pulse, 0);

    // R2 control readback, bit 7 reads 0
    wr(2'd2, 8'hBF);
    rd(2'd2, rv); check("R2 ctrl bits", rv, 8'h3F);
    wr(2'd2, 8'h00);

    // R3 R4 R5 sweep over period, prescaler and postscaler
    for (int pi = 0; pi < 4; pi++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int mi = 0; mi < 3; mi++) begin
          int p, m, n, w, first_m, flag_e, nmatch, guard;
          p = plist[pi]; m = mlist[mi] + 1; n = ratio(sel);
          wr(2'd2, 8'h00);
          wr(2'd3, 8'h00);
          wr(2'd0, 8'h00);
          wr(2'd1, 8'(p));
          wr(2'd2, {1'b0, 1'b1, 4'(mlist[mi]), 2'(sel)});
          w = wr_edge;
          first_m = -1; flag_e = -1; nmatch = 0; guard = 0;
          while (flag_e < 0 && guard < 8000) begin
            if (match_pulse) begin
              nmatch++;
              if (first_m < 0) first_m = edge_n - 1;
            end
            if (irq) flag_e = edge_n - 1;
            else begin @(negedge clk); guard++; end
          end
          check("R3/R4 first match edge", first_m, tick_edge(w, (p + 1) * n));
          check("R5 flag edge", flag_e, tick_edge(w, m * (p + 1) * n));
          check("R5 matches before flag", nmatch, m);
          rd(2'd0, rv); check("R4 count wrapped", rv, 0);
        end
      end
    end

    // R9 flag clear by write to address 3
    wr(2'd2, 8'h00);
    check("R9 flag before clear", irq, 1);
    wr(2'd3, 8'hFF);
    rd(2'd3, rv); check("R9 flag after clear", rv, 0);
    check("R9 irq after clear", irq, 0);

    // R6 count write restarts the prescaler (1:16), period FFh
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h42);
    repeat (37) @(negedge clk);
    wr(2'd0, 8'h05);
    begin
      int w, t16;
      w = wr_edge;
      t16 = tick_edge(w, 16);
      while (edge_n < t16) @(negedge clk);
      rd(2'd0, rv); check("R6 count held before 16th tick", rv, 5);
      @(negedge clk);
      rd(2'd0, rv); check("R6 count stepped at 16th tick", rv, 6);
    end

    // R7 control write leaves the count
    wr(2'd2, 8'h42);
    rd(2'd0, rv); check("R7 count after ctrl write", rv, 6);

    // R8 disabled timer holds
    wr(2'd2, 8'h00);
    repeat (300) @(negedge clk);
    rd(2'd0, rv); check("R8 count held while off", rv, 6);
    check("R8 no match while off", match_pulse, 0);

    finish_run();
  end
endmodule